// File: doc/BRIEF.md
# Modem Line Change Detector

This block monitors two asynchronous modem handshake lines of a serial controller: carrier detect and clear-to-send. Each line is brought into the clock domain through a two-flop synchronizer, and its synchronized level can be read. A change on a line counts only if the new level holds for a selectable qualification time. That time is either 1/16 of a bit or one whole bit, measured in ticks of a 16x baud oversample strobe. A qualified change sets a sticky delta flag for that line.

Reading the line register returns both delta flags and both levels, and the read clears both flags. A control register holds one interrupt enable per delta flag and the qualification-time select. A change status bit is high while any enabled delta flag is set. A separate mask bit gates this status bit onto the processor interrupt. The reset values leave both enables off. Software can therefore clear a delta flag that appeared at start-up before it turns the interrupt on.

Top module: `modem_line_watch`

## Requirements
- R1: The level bits of the line register (address 0; bit 2 = carrier detect, bit 3 = clear-to-send) show each input after two synchronizer flops. A level driven before a clock edge appears after the second rising edge and not after the first.
- R2: A delta flag (address 0; bit 0 = carrier detect, bit 1 = clear-to-send) sets on the Nth tick strobe seen while the synchronized level differs from the last accepted level. The new level then becomes the accepted level. N is 1 when control bit 2 (address 1) is 0, and 16 when it is 1.
- R3: If the synchronized level returns to the accepted level before the Nth tick, the tick count restarts and no flag is set. A pulse that spans no tick never sets a flag.
- R4: A delta flag stays set until a read of address 0. Such a read clears both flags.
- R5: When a qualified change and a read of address 0 fall in the same cycle, the flag ends up set.
- R6: The change status bit (address 3, bit 0) is 1 exactly when the carrier-detect flag is set with enable bit 0 of address 1, or the clear-to-send flag is set with enable bit 1 of address 1.
- R7: `irq_o` is the change status bit ANDed with the mask bit (address 2, bit 0).
- R8: After reset the control register and the mask bit read 0, both delta flags are 0 and `irq_o` is 0.
- R9: The accepted level of each line resets to low. A line held high through reset therefore sets its delta flag on its first qualified tick after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cd_i | input | 1 | Carrier detect line, asynchronous |
| line_cts_i | input | 1 | Clear-to-send line, asynchronous |
| tick16_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (a read of address 0 clears the flags) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| irq_o | output | 1 | Processor interrupt |

## Verification
Two functions can fall in the same clock edge: the qualifying tick that sets a delta flag, and the read of the line register that clears it. The bench lines up a line change so that the deciding tick strobe and the read strobe are high in the same cycle. It then reads the register without the read strobe and expects the flag to be set. A following read with the strobe must clear the flag. Without this ordering the event would be lost between the value returned and the clear.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
  localparam int unsigned LINES  = 2;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_LINES = 2'd0,
    RA_CTRL  = 2'd1,
    RA_MASK  = 2'd2,
    RA_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mlw_sync.sv
module mlw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mlw_qualify.sv
module mlw_qualify #(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic tick_i,
  input  logic full_i,
  input  logic clr_i,
  output logic delta_o
);
  localparam int unsigned CNT_W = $clog2(TICKS_PER_BIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic             acc_q, acc_d;
  logic             delta_q, delta_d;
  logic             differ, hit;

  always_comb begin
    limit   = full_i ? CNT_W'(TICKS_PER_BIT) : CNT_W'(1);
    differ  = (level_i != acc_q);
    cnt_inc = cnt_q + CNT_W'(1);
    hit     = tick_i && differ && (cnt_inc >= limit);

    if (!differ)     cnt_d = '0;
    else if (hit)    cnt_d = '0;
    else if (tick_i) cnt_d = cnt_inc;
    else             cnt_d = cnt_q;

    acc_d = hit ? level_i : acc_q;

    if (hit)        delta_d = 1'b1;
    else if (clr_i) delta_d = 1'b0;
    else            delta_d = delta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      delta_q <= delta_d;
    end
  end

  assign delta_o = delta_q;

  a_r4_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q && !clr_i) |=> delta_q);
  a_r2_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> delta_q);
  a_r3_accept_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(tick_i));
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(TICKS_PER_BIT));
endmodule

// File: rtl/mlw_regs.sv
module mlw_regs
  import mlw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LINES-1:0]  delta_i,
  input  logic [LINES-1:0]  level_i,
  input  logic              chg_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LINES-1:0]  en_o,
  output logic              full_o,
  output logic              mask_o,
  output logic              clr_o
);
  logic [LINES:0] ctrl_q, ctrl_d;
  logic           mask_q, mask_d;
  logic           ctrl_we, mask_we;
  logic           unused_wdata;

  always_comb begin
    ctrl_we = wr_i && (reg_addr_e'(addr_i) == RA_CTRL);
    mask_we = wr_i && (reg_addr_e'(addr_i) == RA_MASK);
    ctrl_d  = ctrl_we ? wdata_i[LINES:0] : ctrl_q;
    mask_d  = mask_we ? wdata_i[0] : mask_q;
    clr_o   = rd_i && (reg_addr_e'(addr_i) == RA_LINES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      RA_LINES: rdata_o[2*LINES-1:0] = {level_i, delta_i};
      RA_CTRL:  rdata_o[LINES:0]     = ctrl_q;
      RA_MASK:  rdata_o[0]           = mask_q;
      RA_STAT:  rdata_o[0]           = chg_i;
      default:  rdata_o              = '0;
    endcase
  end

  assign en_o   = ctrl_q[LINES-1:0];
  assign full_o = ctrl_q[LINES];
  assign mask_o = mask_q;
  assign unused_wdata = ^wdata_i[DATA_W-1:LINES+1];

  a_r4_clear_only_on_line_read: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> (rd_i && addr_i == ADDR_W'(0)));
endmodule

// File: rtl/modem_line_watch.sv
module modem_line_watch
  import mlw_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_cd_i,
  input  logic              line_cts_i,
  input  logic              tick16_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [LINES-1:0] raw, level, delta, en;
  logic             full, mask, clr, chg;

  assign raw = {line_cts_i, line_cd_i};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    mlw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw[i]),
      .q_o   (level[i])
    );
    mlw_qualify #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (level[i]),
      .tick_i  (tick16_i),
      .full_i  (full),
      .clr_i   (clr),
      .delta_o (delta[i])
    );
  end

  mlw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .delta_i (delta),
    .level_i (level),
    .chg_i   (chg),
    .rdata_o (bus_rdata_o),
    .en_o    (en),
    .full_o  (full),
    .mask_o  (mask),
    .clr_o   (clr)
  );

  assign chg   = |(delta & en);
  assign irq_o = chg & mask;

  a_r7_irq_needs_enabled_delta: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(delta & en)));
endmodule

// File: tb/modem_line_watch_test.sv
`timescale 1ns/1ps
module modem_line_watch_test;
  logic       clk;
  logic       rst_n;
  logic       cd, cts, tick;
  logic       wr, rd;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int errs  = 0;
  int total = 0;
  bit done  = 0;

  modem_line_watch uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_cd_i   (cd),
    .line_cts_i  (cts),
    .tick16_i    (tick),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {qual_full, cts, cd, ticks[3:0], expected deltas {cts,cd}}
  localparam logic [8:0] VEC [0:9] = '{
    9'b0_0_1_0000_00,
    9'b0_0_1_0001_01,
    9'b0_1_1_0001_10,
    9'b0_0_0_0001_11,
    9'b1_0_1_1111_00,
    9'b1_0_1_0001_01,
    9'b1_0_0_1111_00,
    9'b1_0_1_0000_00,
    9'b1_0_0_1111_00,
    9'b1_0_0_0001_01
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    rd   = 1'b1;
    #1;
    v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cd = 1'b0; cts = 1'b0; tick = 1'b0;
    wr = 1'b0; rd = 1'b0; addr = 2'd0; wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    peek(2'd1, v); check("R8 ctrl", v, 8'h00);
    peek(2'd2, v); check("R8 mask", v, 8'h00);
    peek(2'd0, v); check("R8 lines", v, 8'h00);
    peek(2'd3, v); check("R8 status", v, 8'h00);
    check("R8 irq", {7'd0, irq}, 8'h00);

    // R1: two-flop delay on the level bit
    @(negedge clk); cd = 1'b1;
    @(negedge clk); peek(2'd0, v); check("R1 level after one edge", {7'd0, v[2]}, 8'h00);
    @(negedge clk); peek(2'd0, v); check("R1 level after two edges", {7'd0, v[2]}, 8'h01);

    // R1/R2/R3: vector table
    for (int i = 0; i < 10; i++) begin
      bus_write(2'd1, {5'd0, VEC[i][8], 2'b00});
      @(negedge clk);
      cts = VEC[i][7];
      cd  = VEC[i][6];
      settle();
      ticks(int'(VEC[i][5:2]));
      bus_read(2'd0, v);
      check("R2/R3 deltas", {6'd0, v[1:0]}, {6'd0, VEC[i][1:0]});
      check("R1 levels", {6'd0, v[3:2]}, {6'd0, VEC[i][7], VEC[i][6]});
    end

    // R3: one-cycle glitch spanning no tick, short qualification
    bus_write(2'd1, 8'h00);
    @(negedge clk); cd = 1'b1;
    @(negedge clk); cd = 1'b0;
    repeat (4) @(negedge clk);
    ticks(2);
    bus_read(2'd0, v);
    check("R3 glitch ignored", {6'd0, v[1:0]}, 8'h00);

    // R5: qualifying tick and clearing read in the same cycle
    @(negedge clk); cd = 1'b1;
    settle();
    @(negedge clk);
    tick = 1'b1; rd = 1'b1; addr = 2'd0;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0;
    repeat (5) @(negedge clk);
    peek(2'd0, v); check("R5 set wins over clear", {6'd0, v[1:0]}, 8'h01);
    bus_read(2'd0, v);
    peek(2'd0, v); check("R4 read clears", {6'd0, v[1:0]}, 8'h00);

    // R6/R7: both flags set, every enable and mask pair
    @(negedge clk); cd = 1'b0; cts = 1'b1;
    settle();
    ticks(1);
    for (int en = 0; en < 4; en++) begin
      for (int m = 0; m < 2; m++) begin
        bus_write(2'd1, 8'(en));
        bus_write(2'd2, 8'(m));
        peek(2'd3, v);
        check("R6 status both flags", v, {7'd0, en != 0});
        check("R7 irq", {7'd0, irq}, {7'd0, (en != 0) && (m != 0)});
      end
    end
    bus_read(2'd0, v);
    @(negedge clk);
    peek(2'd3, v); check("R6 status after clear", v, 8'h00);
    check("R7 irq after clear", {7'd0, irq}, 8'h00);

    // R6/R7: only the carrier-detect flag set
    @(negedge clk); cd = 1'b1;
    settle();
    ticks(1);
    bus_write(2'd1, 8'h02);
    peek(2'd3, v); check("R6 other enable only", v, 8'h00);
    check("R7 irq other enable", {7'd0, irq}, 8'h00);
    bus_write(2'd1, 8'h01);
    peek(2'd3, v); check("R6 matching enable", v, 8'h01);
    check("R7 irq matching enable", {7'd0, irq}, 8'h01);
    peek(2'd0, v); check("R4 flag still held", {6'd0, v[1:0]}, 8'h01);
    bus_read(2'd0, v);

    // R8/R9: reset with both lines high
    @(negedge clk); cd = 1'b1; cts = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd1, v); check("R8 ctrl after second reset", v, 8'h00);
    peek(2'd2, v); check("R8 mask after second reset", v, 8'h00);
    check("R8 irq after second reset", {7'd0, irq}, 8'h00);
    settle();
    ticks(1);
    peek(2'd0, v); check("R9 high line flags after reset", {6'd0, v[1:0]}, 8'h03);
    bus_read(2'd0, v);
    peek(2'd0, v); check("R9 start-up flags cleared by read", {6'd0, v[1:0]}, 8'h00);

    finish_run();
  end
endmodule